// File: doc/BRIEF.md
# Dual Alarm Match and Interrupt Unit

This unit holds two time-of-day alarms and decides, once per second, whether the running clock has reached either of them. Each alarm has four byte fields: seconds, minutes, hours and weekday. Any field can be taken out of the comparison by setting its top bit. A time counter outside the block presents the current time bytes. It pulses a one-cycle second tick when those bytes have just taken a new value, and the unit compares only on that tick.

A matching alarm sets a sticky flag. Each flag can raise an active-low interrupt output when its enable bit is set. A split bit in the control byte chooses between two arrangements: both alarms share the first output, or the second alarm gets an output of its own. The host reads and writes the alarm fields, the control byte and the read-only status byte through a simple single-cycle register port. Any host access, read or write, to one of an alarm's four fields clears that alarm's flag. This is how software acknowledges the interrupt.

Top module: `alarm_irq_unit`

## Requirements
- R1: After reset every alarm field, the control byte and both flags are zero, and `irq0_n` and `irq1_n` are both high.
- R2: Alarm 0 fields sit at addresses 0x07 (seconds), 0x08 (minutes), 0x09 (hours) and 0x0A (weekday), and alarm 1 fields sit at 0x0B to 0x0E in the same order. A write stores the full byte, and a read returns it unchanged.
- R3: An alarm's flag is set at the clock edge where `sec_tick` is high and every field of that alarm matches. The flag never sets on an edge without `sec_tick`, even when the time bytes match.
- R4: A field with bit 7 set matches any time byte. A field with bit 7 clear matches only a time byte equal to it in all 8 bits.
- R5: The hours field is compared as a full byte, including bits 6 and 5. A 24-hour value 0x08 therefore does not match a time byte of 0x48.
- R6: The control byte at 0x0F stores and reads back all 8 bits. Bit 0 enables the alarm 0 interrupt, bit 1 enables the alarm 1 interrupt, and bit 2 is the split bit.
- R7: The status byte at 0x10 reads the alarm 0 flag in bit 0 and the alarm 1 flag in bit 1, with all other bits zero. Writes to 0x10 have no effect.
- R8: A read or a write to any of an alarm's four addresses clears that alarm's flag at that edge. The other alarm's flag is unaffected, and accesses to 0x0F and 0x10 clear no flag.
- R9: When a clearing access and a matching tick reach the same alarm in the same cycle, the flag ends set.
- R10: `irq0_n` is low exactly when the alarm 0 flag and enable are both set, or when the split bit is clear and the alarm 1 flag and enable are both set.
- R11: `irq1_n` is low exactly when the split bit is set and the alarm 1 flag and enable are both set. With the split bit clear it stays high.
- R12: A flag sets whether or not its enable is set. Setting the enable later pulls the routed output low on the edge that writes the control byte.
- R13: Addresses outside 0x07 to 0x10 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse: the time bytes have just updated |
| now_sec | input | 8 | Current seconds byte |
| now_min | input | 8 | Current minutes byte |
| now_hour | input | 8 | Current hours byte, including format bits |
| now_wday | input | 8 | Current weekday byte |
| acc_valid | input | 1 | Host access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid combinationally during a read access, otherwise zero |
| irq0_n | output | 1 | First interrupt output, active low |
| irq1_n | output | 1 | Second interrupt output, active low |

## Verification
The bench builds the unit with its default parameters: 8-bit data and address, alarm fields from 0x07, control at 0x0F and status at 0x10. With these values the full-byte comparison is in reach, with bit 7 acting as the mask. So are both alarm windows and the addresses on either side of them, such as 0x06, 0x0F and 0x11, where flag clearing must start and stop. Random time bytes are drawn mostly from the programmed alarm values, so matches, masked fields, single-field misses and same-cycle clear-and-set collisions all occur often under every split and enable setting.

// File: rtl/alarm_irq_pkg.sv
// Shared constants for the dual alarm unit: number of alarms, number
// of byte fields per alarm, and control bit positions.
// Assumes exactly two alarms; the routing logic depends on that.
package alarm_irq_pkg;
    localparam int NUM_ALARMS = 2;
    localparam int NUM_FIELDS = 4;   // seconds, minutes, hours, weekday
    localparam int CTRL_EN0   = 0;
    localparam int CTRL_EN1   = 1;
    localparam int CTRL_SPLIT = 2;
endpackage

// File: rtl/alarm_slot.sv
// One alarm: its byte fields, the per-field match with top-bit mask,
// and the sticky match flag.
// Assumes now_bytes holds field 0 (seconds) in its lowest byte, and that
// sec_tick is high only in a cycle where those bytes are new.
module alarm_slot
    import alarm_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int BASE   = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         acc_valid,
    input  logic                         acc_write,
    input  logic [ADDR_W-1:0]            acc_addr,
    input  logic [DATA_W-1:0]            acc_wdata,
    input  logic                         sec_tick,
    input  logic [NUM_FIELDS*DATA_W-1:0] now_bytes,
    output logic                         flag,
    output logic [DATA_W-1:0]            rd_data
);
    localparam int MASK_BIT = DATA_W - 1;

    logic [NUM_FIELDS-1:0]             fsel;
    logic [NUM_FIELDS-1:0]             fhit;
    logic [NUM_FIELDS-1:0][DATA_W-1:0] field_v;
    logic                              all_hit;
    logic                              set_ev;
    logic                              clr_ev;
    logic                              flag_q;

    generate
        for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
            localparam logic [ADDR_W-1:0] FADDR = ADDR_W'(BASE + i);
            logic [DATA_W-1:0] val_q;

            assign fsel[i] = (acc_addr == FADDR);

            // Hold the field byte; load it on a host write to its address.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    val_q <= '0;
                else if (acc_valid && acc_write && fsel[i])
                    val_q <= acc_wdata;
            end

            assign field_v[i] = val_q;
            // A field matches when masked or equal in every bit.
            assign fhit[i] = val_q[MASK_BIT] ||
                             (val_q == now_bytes[i*DATA_W +: DATA_W]);
        end
    endgenerate

    // Read data for whichever field the address selects, else zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_FIELDS; i++)
            if (fsel[i]) rd_data = rd_data | field_v[i];
    end

    assign all_hit = &fhit;
    assign set_ev  = sec_tick && all_hit;
    assign clr_ev  = acc_valid && (|fsel);

    // Sticky flag: a match wins over a same-cycle clearing access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (set_ev)
            flag_q <= 1'b1;
        else if (clr_ev)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R3
    flag_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !sec_tick) |=> !flag_q);

    // R3
    flag_sets_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && all_hit) |=> flag_q);

    // R8
    flag_clears_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (|fsel) && !(sec_tick && all_hit)) |=> !flag_q);

    // R2
    field_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && fsel[0]) |=> (field_v[0] == $past(acc_wdata)));
endmodule

// File: rtl/alarm_irq_route.sv
// Maps the two alarm flags and enables onto the two active-low interrupt
// outputs, under the split bit.
// Assumes two alarms. The outputs are combinational from registered
// flags and control bits.
module alarm_irq_route (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] flags,
    input  logic [1:0] enables,
    input  logic       split,
    output logic       irq0_n,
    output logic       irq1_n
);
    logic act0;
    logic act1;

    // Qualify each flag by its enable.
    always_comb begin
        act0 = flags[0] && enables[0];
        act1 = flags[1] && enables[1];
    end

    // Route alarm 1 to the shared or its own output; drive active low.
    always_comb begin
        irq0_n = !(act0 || (act1 && !split));
        irq1_n = !(act1 && split);
    end

    // R11
    shared_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !split |-> irq1_n);

    // R10
    alarm0_drives_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && enables[0]) |-> !irq0_n);

    // R10
    first_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(flags[0] && enables[0]) && split) |-> irq0_n);
endmodule

// File: rtl/alarm_irq_unit.sv
// Top of the dual alarm unit. Holds the control byte, builds the status
// byte, runs the host read mux, and instantiates the alarm slots and the
// interrupt router.
// Assumes a single-cycle host access: the write takes effect at the edge,
// and read data is combinational during the access cycle.
module alarm_irq_unit
    import alarm_irq_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int ALM_BASE  = 7,
    parameter int CTRL_ADDR = 15,
    parameter int STAT_ADDR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [DATA_W-1:0] now_sec,
    input  logic [DATA_W-1:0] now_min,
    input  logic [DATA_W-1:0] now_hour,
    input  logic [DATA_W-1:0] now_wday,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              irq0_n,
    output logic              irq1_n
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic [NUM_FIELDS*DATA_W-1:0] now_bytes;
    logic [NUM_ALARMS-1:0]        flag_v;
    logic [DATA_W-1:0]            slot_rd [NUM_ALARMS];
    logic [DATA_W-1:0]            ctrl_q;
    logic [DATA_W-1:0]            status_v;
    logic [DATA_W-1:0]            rd_mux;

    assign now_bytes = {now_wday, now_hour, now_min, now_sec};

    generate
        for (genvar k = 0; k < NUM_ALARMS; k++) begin : g_alarm
            alarm_slot #(
                .DATA_W (DATA_W),
                .ADDR_W (ADDR_W),
                .BASE   (ALM_BASE + k * NUM_FIELDS)
            ) i_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .acc_valid (acc_valid),
                .acc_write (acc_write),
                .acc_addr  (acc_addr),
                .acc_wdata (acc_wdata),
                .sec_tick  (sec_tick),
                .now_bytes (now_bytes),
                .flag      (flag_v[k]),
                .rd_data   (slot_rd[k])
            );
        end
    endgenerate

    // Control byte: fully writable, low three bits functional.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (acc_valid && acc_write && (acc_addr == CTRL_A))
            ctrl_q <= acc_wdata;
    end

    // Status byte: flags in the enable positions, the rest zero.
    assign status_v = {{(DATA_W - NUM_ALARMS){1'b0}}, flag_v};

    // Host read mux: alarm fields, control, status, else zero.
    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_ALARMS; k++)
            rd_mux = rd_mux | slot_rd[k];
        if (acc_addr == CTRL_A) rd_mux = ctrl_q;
        if (acc_addr == STAT_A) rd_mux = status_v;
    end

    // Present read data only during a read access.
    assign acc_rdata = (acc_valid && !acc_write) ? rd_mux : '0;

    alarm_irq_route i_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flag_v[1:0]),
        .enables ({ctrl_q[CTRL_EN1], ctrl_q[CTRL_EN0]}),
        .split   (ctrl_q[CTRL_SPLIT]),
        .irq0_n  (irq0_n),
        .irq1_n  (irq1_n)
    );

    // R6
    ctrl_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (acc_addr == CTRL_A)) |=> (ctrl_q == $past(acc_wdata)));

    // R7
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && (acc_addr == STAT_A) && !sec_tick) |=> $stable(flag_v));
endmodule

// File: tb/test_alarm_irq_unit.sv
`timescale 1ns/1ps
module test_alarm_irq_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] now_sec = '0, now_min = '0, now_hour = '0, now_wday = '0;
    logic       acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0] acc_addr = '0, acc_wdata = '0;
    logic [7:0] acc_rdata;
    logic       irq0_n, irq1_n;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_alm [2][4];
    logic [7:0] m_ctrl;
    logic [1:0] m_flag;

    always #10 clk = ~clk;

    alarm_irq_unit i_alarm_irq_unit (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_wday(now_wday),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .irq0_n(irq0_n), .irq1_n(irq1_n)
    );

    // Expected read value from the register map in the requirements.
    function automatic logic [7:0] exp_rd(logic [7:0] ad);
        if (ad >= 8'h07 && ad <= 8'h0E) return m_alm[(ad - 8'h07) / 4][(ad - 8'h07) % 4];
        if (ad == 8'h0F) return m_ctrl;
        if (ad == 8'h10) return {6'b0, m_flag};
        return 8'h00;
    endfunction

    // Alarm k matches time tm (seconds in the low byte), bit 7 masking a field.
    function automatic bit alarm_hit(int k, logic [31:0] tm);
        for (int f = 0; f < 4; f++)
            if (!m_alm[k][f][7] && (m_alm[k][f] != tm[f*8 +: 8])) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle of stimulus starting at a falling edge; checks read data
    // mid-cycle and both interrupt outputs after the rising edge.
    task automatic step(string tag, bit av, bit aw, logic [7:0] ad, logic [7:0] wd,
                        bit tk, logic [31:0] tm);
        bit [1:0] hit;
        acc_valid = av; acc_write = aw; acc_addr = ad; acc_wdata = wd;
        {now_wday, now_hour, now_min, now_sec} = tm;
        sec_tick = tk;
        #2;
        if (av && !aw) chk(tag, acc_rdata, exp_rd(ad));
        for (int k = 0; k < 2; k++) hit[k] = tk && alarm_hit(k, tm);
        @(posedge clk);
        #1;
        for (int k = 0; k < 2; k++)
            if (av && ad >= 8'(7 + 4*k) && ad < 8'(11 + 4*k)) m_flag[k] = 1'b0;
        if (av && aw) begin
            if (ad >= 8'h07 && ad <= 8'h0E) m_alm[(ad - 8'h07) / 4][(ad - 8'h07) % 4] = wd;
            else if (ad == 8'h0F) m_ctrl = wd;
        end
        for (int k = 0; k < 2; k++) if (hit[k]) m_flag[k] = 1'b1;
        chk("R10", {7'b0, irq0_n},
            {7'b0, !((m_flag[0] && m_ctrl[0]) || (!m_ctrl[2] && m_flag[1] && m_ctrl[1]))});
        chk("R11", {7'b0, irq1_n}, {7'b0, !(m_ctrl[2] && m_flag[1] && m_ctrl[1])});
        acc_valid = 1'b0; acc_write = 1'b0; sec_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] ad, logic [7:0] wd);
        step("", 1'b1, 1'b1, ad, wd, 1'b0, 32'h0);
    endtask

    task automatic rd(string tag, logic [7:0] ad);
        step(tag, 1'b1, 1'b0, ad, 8'h00, 1'b0, 32'h0);
    endtask

    task automatic tick(logic [31:0] tm);
        step("", 1'b0, 1'b0, 8'h00, 8'h00, 1'b1, tm);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] tm;
        void'($urandom(32'd20240611));
        for (int k = 0; k < 2; k++) for (int f = 0; f < 4; f++) m_alm[k][f] = 8'h00;
        m_ctrl = 8'h00; m_flag = 2'b00;

        repeat (3) @(negedge clk);
        // R1: outputs idle while in reset
        chk("R1", {6'b0, irq1_n, irq0_n}, 8'h03);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 6; a <= 18; a++) rd("R1", 8'(a));   // R1 / R13

        // R2: program both alarms and read back
        wr(8'h07, 8'h10); wr(8'h08, 8'h20); wr(8'h09, 8'h08); wr(8'h0A, 8'h03);
        wr(8'h0B, 8'h80); wr(8'h0C, 8'h80); wr(8'h0D, 8'h80); wr(8'h0E, 8'h80);
        for (int a = 7; a <= 14; a++) rd("R2", 8'(a));

        // R3: matching bytes without a tick set nothing; a one-field miss sets nothing
        step("", 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 32'h03082010);
        rd("R3", 8'h10);
        wr(8'h0B, 8'h01);   // alarm 1 seconds = 0x01 so it stays quiet
        tick(32'h03082011);
        rd("R3", 8'h10);
        tick(32'h03082010);
        rd("R3", 8'h10);

        // R12: flag held with enable off; enabling pulls irq0_n low
        chk("R12", {7'b0, irq0_n}, 8'h01);
        wr(8'h0F, 8'h01);
        chk("R12", {7'b0, irq0_n}, 8'h00);

        // R8: control, status and alarm 1 accesses leave flag 0; an alarm 0 read clears it
        rd("R8", 8'h0F); rd("R8", 8'h10); rd("R8", 8'h0E); rd("R8", 8'h06);
        rd("R8", 8'h10);
        rd("R8", 8'h09);
        rd("R8", 8'h10);

        // R4: masked minutes match anything
        wr(8'h08, 8'h80);
        tick(32'h03085910);
        rd("R4", 8'h10);
        wr(8'h0A, 8'h03);   // write clears flag 0 (R8)
        rd("R8", 8'h10);

        // R5: 12-hour encoded time byte does not match a 24-hour field
        tick(32'h03481210);
        rd("R5", 8'h10);

        // R9: clearing access and matching tick in the same cycle: flag stays set
        step("", 1'b1, 1'b0, 8'h07, 8'h00, 1'b1, 32'h03081210);
        rd("R9", 8'h10);

        // R10 / R11: routing of alarm 1 under the split bit
        wr(8'h0B, 8'h80);
        rd("R8", 8'h07);    // clear alarm 0
        tick(32'h00000000);
        rd("R10", 8'h10);
        wr(8'h0F, 8'h02);   // alarm 1 enabled, shared output
        chk("R10", {7'b0, irq0_n}, 8'h00);
        wr(8'h0F, 8'h06);   // split: alarm 1 on its own output
        chk("R11", {6'b0, irq1_n, irq0_n}, 8'h01);
        rd("R6", 8'h0F);
        wr(8'h0F, 8'hF8);   // upper bits stored, functions off
        rd("R6", 8'h0F);

        // R7: status writes ignored
        wr(8'h10, 8'h00);
        rd("R7", 8'h10);
        // R13: unmapped writes change nothing
        wr(8'h11, 8'h5A); wr(8'h06, 8'hA5);
        rd("R13", 8'h11); rd("R13", 8'h06); rd("R13", 8'h07);

        // Random phase: mixed writes, reads, ticks and collisions
        for (int n = 0; n < 4000; n++) begin
            int op;
            int k;
            op = int'($urandom % 6);
            k  = int'($urandom % 2);
            for (int f = 0; f < 4; f++)
                tm[f*8 +: 8] = ($urandom % 4 != 0) ? (m_alm[k][f] & 8'h7F) : 8'($urandom);
            case (op)
                0: wr(8'(7 + $urandom % 8),
                      ($urandom % 4 == 0) ? 8'($urandom | 32'h80) : 8'($urandom % 8));
                1: wr(8'h0F, 8'($urandom));
                2: rd("R7", 8'(5 + $urandom % 14));
                3: tick(tm);
                4: step("R9", 1'b1, 1'b0, 8'(7 + $urandom % 10), 8'h00, 1'b1, tm);
                default: rd("R3", 8'h10);
            endcase
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule